// File: doc/BRIEF.md
# Thermal Sensor Auto-Monitor Controller

This block watches an on-chip temperature sensor ADC without software having to poll it. Once automatic monitoring is switched on, it waits a programmable number of millisecond ticks. It then converts every active channel, lowest index first, through a request/acknowledge port to the ADC, and keeps the latest code of each channel for readback. Each new code is compared with two per-channel limits, one for the interrupt and one for shutdown. A run of consecutive over-limit samples of programmable length raises a pending interrupt bit or latches a shutdown.

While the most recent sample of any channel is over either of its limits, the controller waits a second, shorter interval between rounds. A latched shutdown is steered per channel to a GPIO-style pin, to a pin wired to the reset controller, or to both. Both pins share one programmable active level. Software reaches everything through a flat register port: a write strobe with address and data, and a combinational read with its own address.

The sensor may produce codes that fall as temperature rises. In that case "hotter than the limit" means a code below the limit. A parameter selects this falling sense or the rising sense.

Top module: `thermal_watch_ctrl`

## Requirements
- R1: Register map with reset values. Offset 0x04 is control: bit 0 auto enable, bit 4+n channel n active, bit 8 pin polarity (1 = active high); reset 0. Offset 0x08 holds enables: bit n interrupt enable, bit 4+n shutdown to GPIO pin, bit 8+n shutdown to reset pin; reset 0. Per-channel interrupt limits are at 0x30+4n and shutdown limits at 0x40+4n; both reset to 0. Interrupt debounce is at 0x60 and shutdown debounce at 0x64; both reset to 4. The normal interval is at 0x68 (reset 250) and the hot interval at 0x6c (reset 50). Unmapped offsets and unused bits read 0.
- R2: Offset 0x20+4n reads back the latest code of channel n, which is CODE_W bits wide (12 by default). All bits above the code width read 0. The register is updated in the cycle the ADC acknowledges the conversion.
- R3: With auto enable set and no round running, the interval counter advances on each tick. On the tick that brings it to the interval length, a round starts if any channel is active. The round converts each active channel in ascending index order. The request is held with a stable channel number until acknowledged, and only one request is outstanding at a time.
- R4: The hot interval replaces the normal interval while the latest sample of any channel is over its interrupt or shutdown limit.
- R5: With the default falling sense, a sample is over a limit when the code is strictly below it. An equal code is not over. The rising sense uses strictly above.
- R6: The interrupt debounce counter of a channel counts consecutive over-limit samples and returns to zero on any sample that is not over. When the count reaches the debounce value, pending bit n is set. A debounce value of 0 acts as 1.
- R7: Pending bits at 0x0c are cleared by writing a one to them. A pending bit set in the same cycle as a clear stays set. The interrupt output is the OR of the pending bits whose enables are set.
- R8: The shutdown debounce counts the same way against the shutdown limit. When it completes, the channel's shutdown is latched until reset. Each pin is asserted when any latched channel is routed to it. An asserted pin drives 1 if polarity is 1 and 0 if polarity is 0, and an idle pin drives the opposite level.
- R9: Clearing auto enable lets a request already raised run to its acknowledge. After that no further request is issued.
- R10: An interval value of 0 acts as 1, so a round can start on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Write byte offset |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 8 | Read byte offset |
| reg_rdata | output | 32 | Read data for reg_raddr |
| adc_req | output | 1 | Conversion request, held until acknowledged |
| adc_chan | output | $clog2(NCH) | Channel to convert |
| adc_ack | input | 1 | Conversion done, adc_code valid |
| adc_code | input | CODE_W | Converted code |
| irq | output | 1 | Interrupt, OR of enabled pending bits |
| shut_gpio | output | 1 | Shutdown pin toward a GPIO |
| shut_rst | output | 1 | Shutdown pin toward the reset controller |

## Verification
Two functions can land in the same cycle: a pending bit being set by a debounce that completes, and a software write that clears that bit. The bench provokes this by writing one to the pending register on every cycle for a long stretch while a channel stays over its interrupt limit. Acknowledges therefore arrive in cycles where the clear is also applied. The behavioural model applies the rule that a set beats a clear and is compared every cycle against the pending readback and the interrupt pin.

// File: rtl/thw_pkg.sv
package thw_pkg;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_BUSY = 1'b1
  } seq_st_t;

  localparam logic [7:0] A_CTRL = 8'h04;
  localparam logic [7:0] A_IEN  = 8'h08;
  localparam logic [7:0] A_PEND = 8'h0C;
  localparam logic [7:0] A_CODE = 8'h20;
  localparam logic [7:0] A_ITHR = 8'h30;
  localparam logic [7:0] A_STHR = 8'h40;
  localparam logic [7:0] A_IDEB = 8'h60;
  localparam logic [7:0] A_SDEB = 8'h64;
  localparam logic [7:0] A_NIVL = 8'h68;
  localparam logic [7:0] A_HIVL = 8'h6C;

  function automatic logic [7:0] ch_addr(input logic [7:0] base, input int idx);
    return base + 8'(idx * 4);
  endfunction

endpackage

// File: rtl/thw_regs.sv
module thw_regs
  import thw_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int CODE_W = 12,
  parameter int IVL_W  = 16,
  parameter int DEB_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [7:0]                    wr_addr,
  input  logic [31:0]                   wr_data,
  input  logic [7:0]                    rd_addr,
  output logic [31:0]                   rd_data,
  input  logic [NCH-1:0][CODE_W-1:0]    codes,
  input  logic [NCH-1:0]                evt,
  output logic                          auto_en,
  output logic [NCH-1:0]                act,
  output logic                          pol_high,
  output logic [NCH-1:0]                ien,
  output logic [NCH-1:0]                to_gpio,
  output logic [NCH-1:0]                to_rst,
  output logic [NCH-1:0]                pend,
  output logic [NCH-1:0][CODE_W-1:0]    ithr,
  output logic [NCH-1:0][CODE_W-1:0]    sthr,
  output logic [DEB_W-1:0]              ideb,
  output logic [DEB_W-1:0]              sdeb,
  output logic [IVL_W-1:0]              nivl,
  output logic [IVL_W-1:0]              hivl
);

  logic                       auto_d, pol_d;
  logic [NCH-1:0]             act_d, ien_d, gpio_d, rst_d, pend_d, clr;
  logic [NCH-1:0][CODE_W-1:0] ithr_d, sthr_d;
  logic [DEB_W-1:0]           ideb_d, sdeb_d;
  logic [IVL_W-1:0]           nivl_d, hivl_d;
  logic                       unused_wdata;

  assign unused_wdata = ^wr_data;

  always_comb begin
    auto_d = auto_en;  act_d  = act;     pol_d  = pol_high;
    ien_d  = ien;      gpio_d = to_gpio; rst_d  = to_rst;
    ithr_d = ithr;     sthr_d = sthr;
    ideb_d = ideb;     sdeb_d = sdeb;
    nivl_d = nivl;     hivl_d = hivl;
    clr    = '0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          auto_d = wr_data[0];
          act_d  = wr_data[4 +: NCH];
          pol_d  = wr_data[8];
        end
        A_IEN: begin
          ien_d  = wr_data[0 +: NCH];
          gpio_d = wr_data[4 +: NCH];
          rst_d  = wr_data[8 +: NCH];
        end
        A_PEND:  clr    = wr_data[NCH-1:0];
        A_IDEB:  ideb_d = wr_data[DEB_W-1:0];
        A_SDEB:  sdeb_d = wr_data[DEB_W-1:0];
        A_NIVL:  nivl_d = wr_data[IVL_W-1:0];
        A_HIVL:  hivl_d = wr_data[IVL_W-1:0];
        default: ;
      endcase
      for (int i = 0; i < NCH; i++) begin
        if (wr_addr == ch_addr(A_ITHR, i)) ithr_d[i] = wr_data[CODE_W-1:0];
        if (wr_addr == ch_addr(A_STHR, i)) sthr_d[i] = wr_data[CODE_W-1:0];
      end
    end
    // a completing debounce wins over a simultaneous clear
    pend_d = (pend & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_en  <= 1'b0;
      act      <= '0;
      pol_high <= 1'b0;
      ien      <= '0;
      to_gpio  <= '0;
      to_rst   <= '0;
      pend     <= '0;
      ithr     <= '0;
      sthr     <= '0;
      ideb     <= DEB_W'(4);
      sdeb     <= DEB_W'(4);
      nivl     <= IVL_W'(250);
      hivl     <= IVL_W'(50);
    end else begin
      auto_en  <= auto_d;
      act      <= act_d;
      pol_high <= pol_d;
      ien      <= ien_d;
      to_gpio  <= gpio_d;
      to_rst   <= rst_d;
      pend     <= pend_d;
      ithr     <= ithr_d;
      sthr     <= sthr_d;
      ideb     <= ideb_d;
      sdeb     <= sdeb_d;
      nivl     <= nivl_d;
      hivl     <= hivl_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: begin
        rd_data[0]        = auto_en;
        rd_data[4 +: NCH] = act;
        rd_data[8]        = pol_high;
      end
      A_IEN: begin
        rd_data[0 +: NCH] = ien;
        rd_data[4 +: NCH] = to_gpio;
        rd_data[8 +: NCH] = to_rst;
      end
      A_PEND:  rd_data[NCH-1:0]   = pend;
      A_IDEB:  rd_data[DEB_W-1:0] = ideb;
      A_SDEB:  rd_data[DEB_W-1:0] = sdeb;
      A_NIVL:  rd_data[IVL_W-1:0] = nivl;
      A_HIVL:  rd_data[IVL_W-1:0] = hivl;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == ch_addr(A_CODE, i)) rd_data[CODE_W-1:0] = codes[i];
      if (rd_addr == ch_addr(A_ITHR, i)) rd_data[CODE_W-1:0] = ithr[i];
      if (rd_addr == ch_addr(A_STHR, i)) rd_data[CODE_W-1:0] = sthr[i];
    end
  end

  // R7: every event seen must be pending on the following cycle
  assert_pend_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((pend & $past(evt)) == $past(evt)));

endmodule

// File: rtl/thw_sched.sv
module thw_sched
  import thw_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int IVL_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick,
  input  logic                                 auto_en,
  input  logic [NCH-1:0]                       act,
  input  logic                                 hot,
  input  logic [IVL_W-1:0]                     nivl,
  input  logic [IVL_W-1:0]                     hivl,
  input  logic                                 adc_ack,
  output logic                                 adc_req,
  output logic [$clog2(NCH > 1 ? NCH : 2)-1:0] adc_chan,
  output logic                                 smp_vld
);

  localparam int CH_W = $clog2(NCH > 1 ? NCH : 2);

  seq_st_t           st_q, st_d;
  logic [IVL_W-1:0]  cnt_q, cnt_d, per, per_eff;
  logic [CH_W-1:0]   cur_q, cur_d, first_ix, next_ix;
  logic              first_ok, next_ok, period_hit;

  always_comb begin
    first_ix = '0; first_ok = 1'b0;
    next_ix  = '0; next_ok  = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (act[i]) begin
        first_ix = CH_W'(i);
        first_ok = 1'b1;
        if (i > int'(cur_q)) begin
          next_ix = CH_W'(i);
          next_ok = 1'b1;
        end
      end
    end
  end

  assign per        = hot ? hivl : nivl;
  assign per_eff    = (per == '0) ? IVL_W'(1) : per;
  assign period_hit = ({1'b0, cnt_q} + (IVL_W+1)'(1)) >= {1'b0, per_eff};

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    cur_d = cur_q;
    case (st_q)
      SQ_IDLE: begin
        if (!auto_en) begin
          cnt_d = '0;
        end else if (tick) begin
          if (period_hit) begin
            cnt_d = '0;
            if (first_ok) begin
              st_d  = SQ_BUSY;
              cur_d = first_ix;
            end
          end else begin
            cnt_d = cnt_q + IVL_W'(1);
          end
        end
      end
      default: begin
        if (adc_ack) begin
          if (next_ok && auto_en) begin
            cur_d = next_ix;
          end else begin
            st_d  = SQ_IDLE;
            cnt_d = '0;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      cur_q <= cur_d;
    end
  end

  assign adc_req  = (st_q == SQ_BUSY);
  assign adc_chan = cur_q;
  assign smp_vld  = adc_req && adc_ack;

  // R3: request held with a stable channel until acknowledged
  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && !adc_ack) |=> (adc_req && $stable(adc_chan)));
  // R3: within a round the channel number only rises
  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_req && adc_ack) |=> (!adc_req || (adc_chan > $past(adc_chan))));
  // R9: with auto off no new request starts
  assert_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_en && !adc_req) |=> !adc_req);

endmodule

// File: rtl/thw_chan.sv
module thw_chan #(
  parameter int CODE_W = 12,
  parameter int DEB_W  = 8,
  parameter bit FALLS  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [CODE_W-1:0] code_in,
  input  logic [CODE_W-1:0] ithr,
  input  logic [CODE_W-1:0] sthr,
  input  logic [DEB_W-1:0]  ideb,
  input  logic [DEB_W-1:0]  sdeb,
  output logic [CODE_W-1:0] code_q,
  output logic              over_q,
  output logic              irq_evt,
  output logic              shut_q
);

  logic              hot_i, hot_s, fire_i, fire_s, over_d, shut_d;
  logic [DEB_W-1:0]  icnt_q, scnt_q, icnt_n, scnt_n, icnt_d, scnt_d;
  logic [DEB_W-1:0]  ideb_eff, sdeb_eff;
  logic [CODE_W-1:0] code_d;

  generate
    if (FALLS) begin : g_falling
      assign hot_i = code_in < ithr;
      assign hot_s = code_in < sthr;
    end else begin : g_rising
      assign hot_i = code_in > ithr;
      assign hot_s = code_in > sthr;
    end
  endgenerate

  assign ideb_eff = (ideb == '0) ? DEB_W'(1) : ideb;
  assign sdeb_eff = (sdeb == '0) ? DEB_W'(1) : sdeb;

  always_comb begin
    icnt_n = hot_i ? ((&icnt_q) ? icnt_q : icnt_q + DEB_W'(1)) : '0;
    scnt_n = hot_s ? ((&scnt_q) ? scnt_q : scnt_q + DEB_W'(1)) : '0;
    fire_i = hot_i && (icnt_n >= ideb_eff);
    fire_s = hot_s && (scnt_n >= sdeb_eff);
    icnt_d = upd ? icnt_n : icnt_q;
    scnt_d = upd ? scnt_n : scnt_q;
    code_d = upd ? code_in : code_q;
    over_d = upd ? (hot_i || hot_s) : over_q;
    shut_d = shut_q || (upd && fire_s);
  end

  assign irq_evt = upd && fire_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt_q <= '0;
      scnt_q <= '0;
      code_q <= '0;
      over_q <= 1'b0;
      shut_q <= 1'b0;
    end else begin
      icnt_q <= icnt_d;
      scnt_q <= scnt_d;
      code_q <= code_d;
      over_q <= over_d;
      shut_q <= shut_d;
    end
  end

  // R8: a latched shutdown never releases
  assert_shut_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    shut_q |=> shut_q);
  // R6: an interrupt event needs a sample over the interrupt limit
  assert_evt_needs_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_evt |-> (upd && ((FALLS && code_in < ithr) || (!FALLS && code_in > ithr))));

endmodule

// File: rtl/thermal_watch_ctrl.sv
module thermal_watch_ctrl #(
  parameter int NCH        = 2,
  parameter int CODE_W     = 12,
  parameter bit CODE_FALLS = 1'b1,
  parameter int IVL_W      = 16,
  parameter int DEB_W      = 8
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 tick_ms,
  input  logic                                 reg_wr,
  input  logic [7:0]                           reg_waddr,
  input  logic [31:0]                          reg_wdata,
  input  logic [7:0]                           reg_raddr,
  output logic [31:0]                          reg_rdata,
  output logic                                 adc_req,
  output logic [$clog2(NCH > 1 ? NCH : 2)-1:0] adc_chan,
  input  logic                                 adc_ack,
  input  logic [CODE_W-1:0]                    adc_code,
  output logic                                 irq,
  output logic                                 shut_gpio,
  output logic                                 shut_rst
);

  logic                       auto_en, pol_high, smp_vld;
  logic [NCH-1:0]             act, ien, to_gpio, to_rst, pend, evt, over, shut;
  logic [NCH-1:0][CODE_W-1:0] codes, ithr, sthr;
  logic [DEB_W-1:0]           ideb, sdeb;
  logic [IVL_W-1:0]           nivl, hivl;
  logic                       gpio_on, rst_on;

  thw_regs #(.NCH(NCH), .CODE_W(CODE_W), .IVL_W(IVL_W), .DEB_W(DEB_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr), .wr_addr(reg_waddr), .wr_data(reg_wdata),
    .rd_addr(reg_raddr), .rd_data(reg_rdata),
    .codes(codes), .evt(evt),
    .auto_en(auto_en), .act(act), .pol_high(pol_high),
    .ien(ien), .to_gpio(to_gpio), .to_rst(to_rst), .pend(pend),
    .ithr(ithr), .sthr(sthr), .ideb(ideb), .sdeb(sdeb),
    .nivl(nivl), .hivl(hivl)
  );

  thw_sched #(.NCH(NCH), .IVL_W(IVL_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .tick(tick_ms),
    .auto_en(auto_en), .act(act), .hot(|over),
    .nivl(nivl), .hivl(hivl),
    .adc_ack(adc_ack), .adc_req(adc_req), .adc_chan(adc_chan),
    .smp_vld(smp_vld)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      thw_chan #(.CODE_W(CODE_W), .DEB_W(DEB_W), .FALLS(CODE_FALLS)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .upd(smp_vld && (int'(adc_chan) == g)),
        .code_in(adc_code),
        .ithr(ithr[g]), .sthr(sthr[g]),
        .ideb(ideb), .sdeb(sdeb),
        .code_q(codes[g]), .over_q(over[g]),
        .irq_evt(evt[g]), .shut_q(shut[g])
      );
    end
  endgenerate

  assign irq       = |(pend & ien);
  assign gpio_on   = |(shut & to_gpio);
  assign rst_on    = |(shut & to_rst);
  assign shut_gpio = pol_high ? gpio_on : ~gpio_on;
  assign shut_rst  = pol_high ? rst_on  : ~rst_on;

endmodule

// File: tb/thermal_watch_ctrl_test.sv
module thermal_watch_ctrl_test;

  localparam int NCH   = 2;
  localparam int CW    = 12;
  localparam bit FALLS = 1'b1;
  localparam int CHM   = (1 << NCH) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic wr = 1'b0;
  logic [7:0]  waddr = '0, raddr = '0;
  logic [31:0] wdata = '0;
  wire  [31:0] rdata;
  wire         adc_req;
  wire  [0:0]  adc_chan;
  logic        ack = 1'b0;
  logic [CW-1:0] code = '0;
  wire  irq, shut_gpio, shut_rst;

  int vectors = 0, errors = 0, cyc = 0;
  int adc_val [NCH];
  bit done = 1'b0;

  // behavioural reference state
  int m_ctrl, m_ien, m_pend, m_ideb, m_sdeb, m_nivl, m_hivl, m_cnt, m_cur;
  int m_code[NCH], m_ithr[NCH], m_sthr[NCH], m_icnt[NCH], m_scnt[NCH];
  bit m_over[NCH], m_shut[NCH];
  bit m_busy;

  always #5 clk = ~clk;

  thermal_watch_ctrl uut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick),
    .reg_wr(wr), .reg_waddr(waddr), .reg_wdata(wdata),
    .reg_raddr(raddr), .reg_rdata(rdata),
    .adc_req(adc_req), .adc_chan(adc_chan), .adc_ack(ack), .adc_code(code),
    .irq(irq), .shut_gpio(shut_gpio), .shut_rst(shut_rst)
  );

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s cycle %0d: got %h expected %h", tag, cyc, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 0; m_ien = 0; m_pend = 0; m_ideb = 4; m_sdeb = 4;
    m_nivl = 250; m_hivl = 50; m_cnt = 0; m_cur = 0; m_busy = 0;
    for (int i = 0; i < NCH; i++) begin
      m_code[i] = 0; m_ithr[i] = 0; m_sthr[i] = 0;
      m_icnt[i] = 0; m_scnt[i] = 0; m_over[i] = 0; m_shut[i] = 0;
    end
  endtask

  function automatic int next_act(input int after);
    for (int i = 0; i < NCH; i++)
      if (i > after && m_ctrl[4 + i]) return i;
    return -1;
  endfunction

  function automatic int model_read(input int a);
    for (int i = 0; i < NCH; i++) begin
      if (a == 'h20 + 4 * i) return m_code[i];
      if (a == 'h30 + 4 * i) return m_ithr[i];
      if (a == 'h40 + 4 * i) return m_sthr[i];
    end
    case (a)
      'h04: return m_ctrl;
      'h08: return m_ien;
      'h0c: return m_pend;
      'h60: return m_ideb;
      'h64: return m_sdeb;
      'h68: return m_nivl;
      'h6c: return m_hivl;
      default: return 0;
    endcase
  endfunction

  task automatic model_step();
    bit smp, hi, hs, fi, fs, anyover;
    int ch, ni, ns, per, nx, setm, clr, c;
    smp = m_busy && ack; ch = m_cur; setm = 0; clr = 0;
    hi = 0; hs = 0; fi = 0; fs = 0; ni = 0; ns = 0; c = int'(code);
    if (smp) begin
      hi = FALLS ? (c < m_ithr[ch]) : (c > m_ithr[ch]);
      hs = FALLS ? (c < m_sthr[ch]) : (c > m_sthr[ch]);
      ni = hi ? ((m_icnt[ch] >= 255) ? 255 : m_icnt[ch] + 1) : 0;
      ns = hs ? ((m_scnt[ch] >= 255) ? 255 : m_scnt[ch] + 1) : 0;
      fi = hi && (ni >= ((m_ideb == 0) ? 1 : m_ideb));
      fs = hs && (ns >= ((m_sdeb == 0) ? 1 : m_sdeb));
    end
    anyover = 0;
    for (int i = 0; i < NCH; i++) anyover |= m_over[i];
    per = anyover ? m_hivl : m_nivl;
    if (per == 0) per = 1;
    if (!m_busy) begin
      if (!m_ctrl[0]) m_cnt = 0;
      else if (tick) begin
        if (m_cnt + 1 >= per) begin
          m_cnt = 0;
          nx = next_act(-1);
          if (nx >= 0) begin m_busy = 1; m_cur = nx; end
        end else m_cnt++;
      end
    end else if (ack) begin
      nx = next_act(m_cur);
      if (nx >= 0 && m_ctrl[0]) m_cur = nx;
      else begin m_busy = 0; m_cnt = 0; end
    end
    if (smp) begin
      m_code[ch] = c; m_over[ch] = hi | hs;
      m_icnt[ch] = ni; m_scnt[ch] = ns;
      if (fs) m_shut[ch] = 1;
      if (fi) setm |= (1 << ch);
    end
    if (wr) begin
      for (int i = 0; i < NCH; i++) begin
        if (waddr == 8'('h30 + 4 * i)) m_ithr[i] = wdata & ((1 << CW) - 1);
        if (waddr == 8'('h40 + 4 * i)) m_sthr[i] = wdata & ((1 << CW) - 1);
      end
      case (waddr)
        8'h04: m_ctrl = wdata & (1 | (CHM << 4) | 'h100);
        8'h08: m_ien  = wdata & (CHM | (CHM << 4) | (CHM << 8));
        8'h0c: clr    = wdata & CHM;
        8'h60: m_ideb = wdata & 'hff;
        8'h64: m_sdeb = wdata & 'hff;
        8'h68: m_nivl = wdata & 'hffff;
        8'h6c: m_hivl = wdata & 'hffff;
        default: ;
      endcase
    end
    m_pend = (m_pend & ~clr) | setm;
  endtask

  task automatic compare();
    bit g, r, pol;
    int a;
    string rtag;
    g = 0; r = 0; pol = m_ctrl[8];
    for (int i = 0; i < NCH; i++) begin
      g |= m_shut[i] && m_ien[4 + i];
      r |= m_shut[i] && m_ien[8 + i];
    end
    a = int'(raddr);
    rtag = (a == 'h20 || a == 'h24) ? "R2 code readback" :
           (a == 'h0c) ? "R7 pending readback" : "R1 register readback";
    chk("R3 R4 R9 R10 adc_req", int'(adc_req), int'(m_busy));
    if (m_busy) chk("R3 adc_chan order", int'(adc_chan), m_cur);
    chk("R5 R6 R7 irq", int'(irq), int'(|(m_pend & m_ien & CHM)));
    chk("R8 shut_gpio", int'(shut_gpio), int'(pol ? g : !g));
    chk("R8 shut_rst", int'(shut_rst), int'(pol ? r : !r));
    chk(rtag, int'(rdata), model_read(a));
  endtask

  localparam int NRA = 14;
  function automatic logic [7:0] sweep_addr(input int k);
    case (k % NRA)
      0: return 8'h04;  1: return 8'h08;  2: return 8'h0c;  3: return 8'h20;
      4: return 8'h24;  5: return 8'h30;  6: return 8'h34;  7: return 8'h40;
      8: return 8'h44;  9: return 8'h60; 10: return 8'h64; 11: return 8'h68;
      12: return 8'h6c; default: return 8'h10;
    endcase
  endfunction

  task automatic cycle();
    tick  = (cyc % 3 == 0);
    raddr = sweep_addr(cyc);
    if (ack) ack = 1'b0;
    else if (adc_req) begin
      ack  = 1'b1;
      code = CW'(adc_val[int'(adc_chan)]);
    end
    model_step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    wr = 1'b1; waddr = a; wdata = d;
    cycle();
    wr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    adc_val[0] = 'hA00;
    adc_val[1] = 'hF00;
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run(2 * NRA);                                  // R1 reset values

    wreg(8'h30, 32'h800); wreg(8'h34, 32'h800);
    wreg(8'h40, 32'h400); wreg(8'h44, 32'h400);
    wreg(8'h60, 32'd2);   wreg(8'h64, 32'd3);
    wreg(8'h68, 32'd5);   wreg(8'h6c, 32'd2);
    wreg(8'h08, 32'h0000_0213);                    // irq both, ch0->gpio, ch1->reset
    wreg(8'h04, 32'h0000_0031);                    // auto, both active, low polarity
    run(100);                                      // R3 cool rounds

    adc_val[0] = 'h800;  run(80);                  // R5 equal code is not over
    chk("R5 equal code leaves pending clear", int'(irq), 0);
    adc_val[0] = 'h7FF;  run(100);                 // R4 R6 hot, debounce completes
    chk("R6 irq after debounce", int'(irq), 1);

    wr = 1'b1; waddr = 8'h0c; wdata = 32'h1;       // R7 clear racing with set
    run(60);
    wr = 1'b0;
    adc_val[0] = 'hC00;  run(60);
    wreg(8'h0c, 32'h3);  run(20);
    chk("R7 irq cleared", int'(irq), 0);

    adc_val[1] = 'h3FF;  run(120);                 // R8 shutdown on ch1
    adc_val[1] = 'hFFF;  run(60);
    chk("R8 latched reset pin active low", int'(shut_rst), 0);
    chk("R8 idle gpio pin high", int'(shut_gpio), 1);
    wreg(8'h04, 32'h0000_0131); run(20);
    chk("R8 reset pin active high", int'(shut_rst), 1);

    for (int i = 0; i < 100 && !adc_req; i++) cycle();
    wreg(8'h04, 32'h0000_0130);                    // R9 stop mid-request
    run(80);
    chk("R9 no request after stop", int'(adc_req), 0);

    wreg(8'h68, 32'd0); wreg(8'h6c, 32'd0);        // R10 zero intervals
    wreg(8'h04, 32'h0000_0131); run(60);
    wreg(8'h04, 32'h0000_0121); run(60);           // R3 only ch1 active

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule